// File: doc/BRIEF.md
# LCD Line Fetch Bus Master

This block moves one display line of pixel data out of display memory each horizontal line period. On the rising edge of the line-sync input it asks the CPU for the shared bus. Once the bus is granted, it reads the whole line in a single burst and only then releases the bus. The number of memory words in the burst comes from a segment count and a pixel mode. The pixel mode sets the bits per pixel. The block rounds up to whole bytes and then to whole bus words, so that no partial pixel is cut off.

The cost of each access depends on the kind of display memory in use. External static RAM costs a base of two clocks plus a programmable wait count. Synchronous DRAM and on-chip RAM have fixed access costs, and they also add a fixed setup overhead before the first access of a line. The memory can stretch any access further with a wait input.

The fetched words leave on a valid/ready pixel stream. The block holds a word on the stream until the sink accepts it. It does not start the next memory access while a word is still waiting, so back-pressure from the sink lengthens the time the CPU is kept off the bus. A stall meter counts every clock in which the grant is high. On each line sync it publishes the count for the line period just ended, so software can set the CPU stall time against the line period. A sync that arrives while a fetch is still running does not restart the fetch; it sets a sticky overrun flag.

Top module: `lcd_line_dma`

## Requirements
- R1: A rising edge on `line_sync` while the block is idle, with a nonzero segment count, raises `bus_req` on the next clock. `mem_rd` is asserted only while both `bus_req` and `bus_ack` are high.
- R2: `bus_req` stays high from the request until the last access of the line completes, and then drops. While `bus_ack` is still high after that drop, `bus_req` does not rise again.
- R3: A line is `ceil(ceil(seg_count*K/8)/2)` 16-bit words. They are read from word addresses `base_addr`, `base_addr+1`, and so on, in rising order. They are delivered on the pixel stream in the same order. `pix_last` is high only with the final word of the line.
- R4: The bits per pixel K is set by `pix_mode`: 0→1, 1→2, 2→4, 3→8, 4→12, 5→16, 6→24, 7→24.
- R5: The access cost is set by `mem_kind`. 0 is external static RAM and costs 2+`wait_cnt` clocks. 1 is synchronous DRAM and costs 2 clocks. 2 is on-chip RAM and costs 1 clock. 3 is treated as 0. `mem_rd` stays high for exactly that many clocks when `mem_wait` is low. While `mem_wait` is high, the access is extended and `mem_addr` is held.
- R6: Once the grant is seen, the first `mem_rd` comes after a setup overhead. That overhead is 8 clocks for `mem_kind` 1, 2 clocks for `mem_kind` 2 and 0 for the others. The number of clocks with `bus_ack` high before the first `mem_rd` of a line is 2 plus that overhead.
- R7: A word on the pixel stream keeps `pix_valid`, `pix_data` and `pix_last` steady until a clock in which `pix_ready` is high. No new access starts while an unaccepted word is waiting.
- R8: A `line_sync` rising edge that arrives while a fetch or release is in progress sets `overrun`. `overrun` stays set until reset. The running fetch completes with its original word count.
- R9: `stall_cycles` is loaded at each `line_sync` rising edge with the number of clocks since the previous rising edge in which `bus_ack` was high, not counting the clock of the edge itself. The internal count then restarts from that clock. The value is 0 after reset.
- R10: A line sync with a segment count of zero starts no request.
- R11: Segment count, pixel mode, memory kind, wait count and base address are captured at the line start. They stay fixed for the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_sync | input | 1 | Horizontal line sync; the rising edge starts a fetch |
| seg_count | input | SEG_W | Number of segments (pixels) in a line |
| pix_mode | input | 3 | Pixel mode selecting bits per pixel |
| mem_kind | input | 2 | Display memory type selecting access cost and overhead |
| wait_cnt | input | WAIT_W | Extra wait clocks per static RAM access |
| base_addr | input | AW | Word address of the first word of the line |
| bus_req | output | 1 | Bus request to the CPU |
| bus_ack | input | 1 | Bus grant from the CPU |
| mem_rd | output | 1 | Memory read strobe, held for the whole access |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | DW | Memory read data, taken at the end of an access |
| mem_wait | input | 1 | Memory extends the current access while high |
| pix_valid | output | 1 | Pixel stream word valid |
| pix_ready | input | 1 | Pixel stream sink ready |
| pix_data | output | DW | Pixel stream word |
| pix_last | output | 1 | Marks the final word of a line |
| stall_cycles | output | STALL_W | Granted clocks counted over the previous line period |
| overrun | output | 1 | Sticky flag for a sync during a fetch |

## Verification
The bench varies the segment count across all eight pixel modes at a value where rounding up matters. A design that truncated instead would emit one word too few, and the scoreboard would be left holding an expected word. It measures the width of every read strobe and the granted gap before the first read of each memory type. A wrong cost table or a missing overhead shows up as a strobe or gap that is off by whole clocks. A second sync is fired in the middle of a long line: a design that restarted the fetch would re-read the first words and miss the overrun flag. A line with zero segments catches a design that raises a request with nothing to move. The bench also counts the granted clocks of its own bus model between syncs, which exposes a stall meter that is off by one at the sync edge or fails to clear.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;

  typedef enum logic [2:0] {
    PM_MONO   = 3'd0,
    PM_GRAY4  = 3'd1,
    PM_GRAY16 = 3'd2,
    PM_C256   = 3'd3,
    PM_C4K    = 3'd4,
    PM_C64K   = 3'd5,
    PM_C256K  = 3'd6,
    PM_C16M   = 3'd7
  } pix_mode_e;

  typedef enum logic [1:0] {
    MK_SRAM  = 2'd0,
    MK_SDRAM = 2'd1,
    MK_IRAM  = 2'd2,
    MK_SPARE = 2'd3
  } mem_kind_e;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_REQ,
    FS_OVH,
    FS_SLOT,
    FS_ACC,
    FS_REL
  } fetch_st_e;

  function automatic logic [4:0] bits_per_pixel(input pix_mode_e m);
    case (m)
      PM_MONO:   return 5'd1;
      PM_GRAY4:  return 5'd2;
      PM_GRAY16: return 5'd4;
      PM_C256:   return 5'd8;
      PM_C4K:    return 5'd12;
      PM_C64K:   return 5'd16;
      default:   return 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/lcd_len_calc.sv
module lcd_len_calc
  import lcd_dma_pkg::*;
#(
  parameter int SEG_W     = 10,
  parameter int WAIT_W    = 4,
  parameter int DW        = 16,
  parameter int WORD_W    = 13,
  parameter int COST_W    = 5,
  parameter int OVH_W     = 5,
  parameter int SDRAM_OVH = 8,
  parameter int IRAM_OVH  = 2
) (
  input  logic [SEG_W-1:0]  seg_count,
  input  logic [2:0]        pix_mode,
  input  logic [1:0]        mem_kind,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic [WORD_W-1:0] word_total,
  output logic [COST_W-1:0] acc_cost,
  output logic [OVH_W-1:0]  ovh_cycles
);
  localparam int BITS_W = SEG_W + 5;
  localparam int BPW    = DW / 8;
  localparam int WSH    = $clog2(BPW);

  logic [4:0]        k_bits;
  logic [BITS_W-1:0] line_bits;
  logic [BITS_W-1:0] line_bytes;
  logic [BITS_W-1:0] line_words;

  always_comb begin
    k_bits     = bits_per_pixel(pix_mode_e'(pix_mode));
    line_bits  = BITS_W'(seg_count) * BITS_W'(k_bits);
    // round up to whole bytes, then to whole bus words
    line_bytes = (line_bits + BITS_W'(7)) >> 3;
    line_words = (line_bytes + BITS_W'(BPW - 1)) >> WSH;
    word_total = WORD_W'(line_words);
  end

  always_comb begin
    case (mem_kind_e'(mem_kind))
      MK_SDRAM: begin
        acc_cost   = COST_W'(2);
        ovh_cycles = OVH_W'(SDRAM_OVH);
      end
      MK_IRAM: begin
        acc_cost   = COST_W'(1);
        ovh_cycles = OVH_W'(IRAM_OVH);
      end
      default: begin
        acc_cost   = COST_W'(2) + COST_W'(wait_cnt);
        ovh_cycles = '0;
      end
    endcase
  end

endmodule

// File: rtl/lcd_stall_meter.sv
module lcd_stall_meter #(
  parameter int STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               granted,
  input  logic               sync_rise,
  output logic [STALL_W-1:0] stall_last
);
  logic [STALL_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      stall_last <= '0;
    end else if (sync_rise) begin
      stall_last <= run_cnt;
      run_cnt    <= STALL_W'(granted);
    end else if (granted && run_cnt != '1) begin
      run_cnt <= run_cnt + STALL_W'(1);
    end
  end

endmodule

// File: rtl/lcd_fetch_fsm.sv
module lcd_fetch_fsm
  import lcd_dma_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int WORD_W = 13,
  parameter int COST_W = 5,
  parameter int OVH_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_rise,
  input  logic [WORD_W-1:0] word_total,
  input  logic [COST_W-1:0] acc_cost,
  input  logic [OVH_W-1:0]  ovh_cycles,
  input  logic [AW-1:0]     base_addr,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_wait,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [DW-1:0]     pix_data,
  output logic              pix_last,
  output logic              busy
);
  fetch_st_e         st;
  logic [WORD_W-1:0] words_left;
  logic [COST_W-1:0] cost_q;
  logic [COST_W-1:0] acc_cnt;
  logic [OVH_W-1:0]  ovh_q;
  logic [OVH_W-1:0]  ovh_cnt;
  logic [AW-1:0]     addr_q;
  logic              slot_free;
  logic              last_word;

  assign slot_free = !pix_valid || pix_ready;
  assign last_word = (words_left == WORD_W'(1));
  assign bus_req   = (st == FS_REQ) || (st == FS_OVH) || (st == FS_SLOT) || (st == FS_ACC);
  assign mem_rd    = (st == FS_ACC);
  assign mem_addr  = addr_q;
  assign busy      = (st != FS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= FS_IDLE;
      words_left <= '0;
      cost_q     <= '0;
      acc_cnt    <= '0;
      ovh_q      <= '0;
      ovh_cnt    <= '0;
      addr_q     <= '0;
    end else begin
      case (st)
        FS_IDLE: begin
          if (sync_rise && word_total != '0) begin
            words_left <= word_total;
            cost_q     <= acc_cost;
            ovh_q      <= ovh_cycles;
            addr_q     <= base_addr;
            st         <= FS_REQ;
          end
        end
        FS_REQ: begin
          if (bus_ack) begin
            if (ovh_q == '0) begin
              st <= FS_SLOT;
            end else begin
              ovh_cnt <= ovh_q - OVH_W'(1);
              st      <= FS_OVH;
            end
          end
        end
        FS_OVH: begin
          if (ovh_cnt == '0) st <= FS_SLOT;
          else               ovh_cnt <= ovh_cnt - OVH_W'(1);
        end
        FS_SLOT: begin
          if (slot_free) begin
            acc_cnt <= cost_q - COST_W'(1);
            st      <= FS_ACC;
          end
        end
        FS_ACC: begin
          if (acc_cnt != '0) begin
            acc_cnt <= acc_cnt - COST_W'(1);
          end else if (!mem_wait) begin
            words_left <= words_left - WORD_W'(1);
            addr_q     <= addr_q + AW'(1);
            st         <= last_word ? FS_REL : FS_SLOT;
          end
        end
        FS_REL: begin
          if (!bus_ack) st <= FS_IDLE;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  // one-word output slot of the pixel stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_last  <= 1'b0;
    end else begin
      if (pix_valid && pix_ready) pix_valid <= 1'b0;
      if (st == FS_ACC && acc_cnt == '0 && !mem_wait) begin
        pix_valid <= 1'b1;
        pix_data  <= mem_rdata;
        pix_last  <= last_word;
      end
    end
  end

endmodule

// File: rtl/lcd_line_dma.sv
module lcd_line_dma
  import lcd_dma_pkg::*;
#(
  parameter int SEG_W     = 10,
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int WAIT_W    = 4,
  parameter int STALL_W   = 16,
  parameter int SDRAM_OVH = 8,
  parameter int IRAM_OVH  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_sync,
  input  logic [SEG_W-1:0]   seg_count,
  input  logic [2:0]         pix_mode,
  input  logic [1:0]         mem_kind,
  input  logic [WAIT_W-1:0]  wait_cnt,
  input  logic [AW-1:0]      base_addr,
  output logic               bus_req,
  input  logic               bus_ack,
  output logic               mem_rd,
  output logic [AW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_wait,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [DW-1:0]      pix_data,
  output logic               pix_last,
  output logic [STALL_W-1:0] stall_cycles,
  output logic               overrun
);
  localparam int BITS_W  = SEG_W + 5;
  localparam int WORD_W  = BITS_W - 2;
  localparam int COST_W  = WAIT_W + 1;
  localparam int MAX_OVH = (SDRAM_OVH > IRAM_OVH) ? SDRAM_OVH : IRAM_OVH;
  localparam int OVH_W   = $clog2(MAX_OVH + 1) + 1;

  logic              sync_q;
  logic              sync_rise;
  logic              busy;
  logic [WORD_W-1:0] word_total;
  logic [COST_W-1:0] acc_cost;
  logic [OVH_W-1:0]  ovh_cycles;

  assign sync_rise = line_sync && !sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      sync_q <= line_sync;
      if (sync_rise && busy) overrun <= 1'b1;
    end
  end

  lcd_len_calc #(
    .SEG_W(SEG_W), .WAIT_W(WAIT_W), .DW(DW), .WORD_W(WORD_W),
    .COST_W(COST_W), .OVH_W(OVH_W),
    .SDRAM_OVH(SDRAM_OVH), .IRAM_OVH(IRAM_OVH)
  ) u_len (
    .seg_count  (seg_count),
    .pix_mode   (pix_mode),
    .mem_kind   (mem_kind),
    .wait_cnt   (wait_cnt),
    .word_total (word_total),
    .acc_cost   (acc_cost),
    .ovh_cycles (ovh_cycles)
  );

  lcd_fetch_fsm #(
    .AW(AW), .DW(DW), .WORD_W(WORD_W), .COST_W(COST_W), .OVH_W(OVH_W)
  ) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_rise  (sync_rise),
    .word_total (word_total),
    .acc_cost   (acc_cost),
    .ovh_cycles (ovh_cycles),
    .base_addr  (base_addr),
    .bus_req    (bus_req),
    .bus_ack    (bus_ack),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .mem_wait   (mem_wait),
    .pix_valid  (pix_valid),
    .pix_ready  (pix_ready),
    .pix_data   (pix_data),
    .pix_last   (pix_last),
    .busy       (busy)
  );

  lcd_stall_meter #(
    .STALL_W(STALL_W)
  ) u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .granted    (bus_ack),
    .sync_rise  (sync_rise),
    .stall_last (stall_cycles)
  );

endmodule

// File: rtl/lcd_line_dma_chk.sv
module lcd_line_dma_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_ack,
  input logic          mem_rd,
  input logic          mem_wait,
  input logic [AW-1:0] mem_addr,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [DW-1:0] pix_data,
  input logic          pix_last,
  input logic          overrun
);

  assert_rd_granted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_req && bus_ack));

  assert_req_released_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(mem_rd));

  assert_no_rerequest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && bus_ack) |=> !bus_req);

  assert_wait_holds_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr)));

  assert_stream_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

endmodule

bind lcd_line_dma lcd_line_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .mem_rd    (mem_rd),
  .mem_wait  (mem_wait),
  .mem_addr  (mem_addr),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_data  (pix_data),
  .pix_last  (pix_last),
  .overrun   (overrun)
);

// File: tb/lcd_line_dma_tb.sv
`timescale 1ns/1ps
module lcd_line_dma_tb;
  localparam int SEG_W = 10, AW = 20, DW = 16, WAIT_W = 4, STALL_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_sync = 1'b0;
  logic [SEG_W-1:0] seg_count = '0;
  logic [2:0] pix_mode = '0;
  logic [1:0] mem_kind = '0;
  logic [WAIT_W-1:0] wait_cnt = '0;
  logic [AW-1:0] base_addr = '0;
  logic bus_req, bus_ack, mem_rd, mem_wait, pix_valid, pix_ready, pix_last, overrun;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata, pix_data;
  logic [STALL_W-1:0] stall_cycles;

  always #2 clk = ~clk;

  lcd_line_dma u_dut (
    .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .seg_count(seg_count),
    .pix_mode(pix_mode), .mem_kind(mem_kind), .wait_cnt(wait_cnt),
    .base_addr(base_addr), .bus_req(bus_req), .bus_ack(bus_ack),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wait(mem_wait), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_last(pix_last), .stall_cycles(stall_cycles),
    .overrun(overrun)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, ~a[7:0]} ^ {4'h0, a[11:8], 8'h00};
  endfunction

  function automatic int kfn(input int m);
    case (m)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 12;
      5: return 16;
      default: return 24;
    endcase
  endfunction

  function automatic int words_fn(input int seg, input int m);
    return (((seg * kfn(m)) + 7) / 8 + 1) / 2;
  endfunction

  // bus owner model: grant follows request one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else        bus_ack <= bus_req;
  end

  assign mem_rdata = mem_fn(mem_addr);

  // sink ready and memory wait patterns
  bit ready_mode = 0;
  bit wait_mode = 0;
  logic [7:0] lfsr = 8'h5B;
  initial begin
    pix_ready = 1'b1;
    mem_wait  = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pix_ready = ready_mode ? lfsr[0] : 1'b1;
      mem_wait  = wait_mode ? (lfsr[2] & lfsr[6]) : 1'b0;
    end
  end

  // scoreboard and monitors
  logic [DW:0] sbq[$];
  int popped = 0;
  int exp_cost = 0;
  int exp_ovh = 0;
  bit gap_arm = 0;
  int gap = 0;
  int rd_len = 0;
  bit rd_prev = 0;
  bit sync_prev = 0;
  int ack_acc = 0;
  int stall_exp = 0;
  bit stall_pend = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid && pix_ready) begin
        if (sbq.size() == 0) begin
          chk(0, "R3", "unexpected extra word", int'(pix_data), 0);
        end else begin
          logic [DW:0] e;
          e = sbq.pop_front();
          chk(pix_data == e[DW-1:0], "R3", "pixel word", int'(pix_data), int'(e[DW-1:0]));
          chk(pix_last == e[DW], "R3", "last flag", int'(pix_last), int'(e[DW]));
          popped++;
        end
      end
      if (gap_arm) begin
        if (mem_rd) begin
          chk(gap == 2 + exp_ovh, "R6", "granted clocks before first read", gap, 2 + exp_ovh);
          gap_arm = 0;
        end else if (bus_ack) begin
          gap++;
        end
      end
      if (mem_rd) begin
        rd_len++;
      end else if (rd_prev) begin
        if (!wait_mode) chk(rd_len == exp_cost, "R5", "read strobe width", rd_len, exp_cost);
        rd_len = 0;
      end
      rd_prev = mem_rd;
      if (stall_pend) begin
        chk(int'(stall_cycles) == stall_exp, "R9", "stall count", int'(stall_cycles), stall_exp);
        stall_pend = 0;
      end
      if (line_sync && !sync_prev) begin
        stall_exp  = ack_acc;
        ack_acc    = int'(bus_ack);
        stall_pend = 1;
      end else begin
        ack_acc += int'(bus_ack);
      end
      sync_prev = line_sync;
    end
  end

  task automatic pulse_sync();
    line_sync = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    line_sync = 1'b0;
  endtask

  task automatic start_line(input int seg, input int mode, input int kind,
                            input int wt, input int base, output int n);
    @(posedge clk); #1;
    seg_count = SEG_W'(seg);
    pix_mode  = 3'(mode);
    mem_kind  = 2'(kind);
    wait_cnt  = WAIT_W'(wt);
    base_addr = AW'(base);
    exp_cost  = (kind == 1) ? 2 : (kind == 2) ? 1 : 2 + wt;
    exp_ovh   = (kind == 1) ? 8 : (kind == 2) ? 2 : 0;
    n = words_fn(seg, mode);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a;
      a = AW'(base + i);
      sbq.push_back({(i == n - 1) ? 1'b1 : 1'b0, mem_fn(a)});
    end
    popped  = 0;
    gap     = 0;
    gap_arm = (n != 0);
    pulse_sync();
  endtask

  task automatic finish_line(input int n, input string tag);
    while (bus_req || bus_ack || sbq.size() != 0 || pix_valid) @(negedge clk);
    chk(popped == n, "R3", tag, popped, n);
  endtask

  task automatic run_line(input int seg, input int mode, input int kind,
                          input int wt, input int base);
    int n;
    start_line(seg, mode, kind, wt, base, n);
    finish_line(n, "word count");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    int req_hi;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b0, "R1", "reset bus_req", int'(bus_req), 0);
    chk(pix_valid == 1'b0, "R7", "reset pix_valid", int'(pix_valid), 0);
    chk(overrun == 1'b0, "R8", "reset overrun", int'(overrun), 0);
    chk(stall_cycles == '0, "R9", "reset stall", int'(stall_cycles), 0);

    // R1 request timing: bus_req is high one clock after the sync edge
    @(posedge clk); #1;
    seg_count = 10'd13; pix_mode = 3'd0; mem_kind = 2'd0; wait_cnt = '0;
    base_addr = 20'h00100;
    exp_cost = 2; exp_ovh = 0;
    sbq.push_back({1'b1, mem_fn(20'h00100)});
    popped = 0; gap = 0; gap_arm = 1;
    line_sync = 1'b1;
    @(negedge clk);
    chk(bus_req == 1'b0, "R1", "no request before sync edge", int'(bus_req), 0);
    @(negedge clk);
    chk(bus_req == 1'b1, "R1", "request after sync edge", int'(bus_req), 1);
    @(posedge clk); #1 line_sync = 1'b0;
    finish_line(1, "R1 single word line");

    // R4 every pixel mode, with rounding at seg 13; R11 config changes mid-line
    for (int m = 1; m < 8; m++) begin
      start_line(13, m, 0, m % 3, 16'h0200 + m * 40, n);
      seg_count = 10'd1;
      pix_mode  = 3'd0;
      base_addr = 20'h0F000;
      finish_line(n, "R4 R11 words per mode");
    end

    // R5 R6 SDRAM with a throttled sink (R7)
    ready_mode = 1;
    run_line(20, 3, 1, 0, 20'h01000);
    // R6 on-chip RAM, 132 bits rounds to 17 bytes
    run_line(11, 4, 2, 0, 20'h02000);
    ready_mode = 0;
    // R5 spare kind behaves as static RAM
    run_line(9, 5, 3, 5, 20'h03000);
    // R5 memory wait stretches accesses
    wait_mode = 1;
    run_line(24, 5, 0, 1, 20'h04000);
    wait_mode = 0;

    // R10 zero segments: no request
    start_line(0, 6, 0, 0, 20'h05000, n);
    req_hi = 0;
    repeat (12) begin
      @(negedge clk);
      if (bus_req) req_hi++;
    end
    chk(req_hi == 0, "R10", "request clocks for empty line", req_hi, 0);
    chk(overrun == 1'b0, "R8", "no overrun on spaced lines", int'(overrun), 0);

    // R8 sync during a fetch: flag set, fetch not restarted
    start_line(40, 5, 0, 3, 20'h06000, n);
    repeat (20) @(posedge clk);
    #1;
    pulse_sync();
    @(negedge clk);
    chk(overrun == 1'b1, "R8", "overrun after mid-line sync", int'(overrun), 1);
    finish_line(n, "R8 words after overrun");
    run_line(6, 2, 2, 0, 20'h07000);
    chk(overrun == 1'b1, "R8", "overrun sticky", int'(overrun), 1);

    // R2 request not reissued back to back; then publish the last stall count
    run_line(16, 6, 0, 0, 20'h08000);
    start_line(0, 0, 0, 0, 0, n);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

endmodule